// File: doc/BRIEF.md
# PHY power-up sequencer

This block brings a storage-interface PHY out of power-down in hardware. It starts on a one-cycle start pulse. At that moment it captures two inputs: a requested drive impedance in ohms and a measured card-clock frequency in Hz. It turns each into a short code. The impedance goes through a lookup with a fallback value. The frequency is binned against three thresholds.

The block then issues a fixed, ordered series of masked writes to two PHY control registers. It waits a timed interval with the PHY powered down, then releases power-down. It polls a calibration-complete status bit with a bounded number of retries. After that it programs the frequency band and enables the DLL. Last, it polls a DLL-lock status bit, but only when the captured frequency was nonzero. A poll that runs out of retries sets a sticky error flag for that poll, and the series still runs to the end. A done pulse closes each run.

All delays are counted in clock cycles. A parameter gives the number of cycles per microsecond, so the same RTL runs at full scale in silicon and at reduced scale in simulation. The status bits come from the PHY through an 8-bit status input.

Top module: `phy_bringup_seq`

## Requirements
- R1: The impedance request is coded into a 3-bit drive code. The codes are 50 Ω→0, 33 Ω→1, 66 Ω→2, 100 Ω→3 and 40 Ω→4, and any other value gives 0. The code is written to register B bits [6:4].
- R2: The frequency is coded into a 2-bit band code, which is written to register A bits [13:12]. A frequency of 0 Hz gives 0. Below 75 MHz gives 1. Below 125 MHz gives 2. Below 175 MHz gives 3. Anything higher gives 0.
- R3: Each run issues its writes in this fixed order, with wr_sel 0 = register A and 1 = register B. A write changes only the bits set in wr_mask, and its value has no bit outside the mask.
  - (1) B: mask 0x0070, drive code.
  - (2) A: mask 0x0800, value 0x0800, which enables the output tap delay.
  - (3) A: mask 0x0780, value 0x0200, which sets the tap-delay select to 4.
  - (4) B: mask 0x0003, value 0, which asserts power-down and turns the DLL off.
  - (5) B: mask 0x0001, value 1, which releases power-down.
  - (6) A: mask 0x3000, band code.
  - (7) B: mask 0x0002, value 0x0002, which enables the DLL.
- R4: Write (5) comes exactly PD_WAIT_US×CYC_PER_US+1 cycles after write (4).
- R5: The calibration bit is stat_i[6]. It is sampled the cycle after write (5). If it is set, write (6) follows the next cycle. If it is clear, the block waits CAL_GAP_US×CYC_PER_US cycles and samples again, up to POLL_TRIES samples. After the last failed sample and its wait, err_cal_o is set and write (6) follows.
- R6: The DLL-lock bit is stat_i[5]. It is polled in the same way after write (7), using DLL_GAP_US, and its timeout sets err_dll_o. When the captured frequency is 0, it is not polled at all: done_o comes the cycle after write (7) and err_dll_o stays 0.
- R7: busy_o rises the cycle after an accepted start and stays high through the done_o cycle. done_o is a single-cycle pulse. An accepted start clears both error flags.
- R8: A start pulse while busy_o is high is ignored. The run keeps its captured codes and issues exactly seven writes, and the error flags are not cleared.
- R9: After reset, busy_o, done_o, wr_en_o, err_cal_o and err_dll_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, acted on only while idle |
| imp_ohm_i | input | 8 | Requested drive impedance in ohms |
| clk_hz_i | input | 32 | Measured card-clock frequency in Hz |
| stat_i | input | 8 | PHY status: bit 6 calibration complete, bit 5 DLL locked |
| wr_en_o | output | 1 | Register write strobe |
| wr_sel_o | output | 1 | Target register: 0 = A, 1 = B |
| wr_mask_o | output | 16 | Bits that the write updates |
| wr_val_o | output | 16 | Values for the masked bits |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_cal_o | output | 1 | Sticky calibration timeout |
| err_dll_o | output | 1 | Sticky DLL lock timeout |

## Verification
The assertions assume that start_i is a pulse and that imp_ohm_i and clk_hz_i need to be valid only in the cycle a start is accepted. They also assume that stat_i matters only in the sampling cycles of the two polls. The bench sets the impedance, frequency and status levels before each start and holds the status level constant for the whole run, so each poll either succeeds on its first sample or times out. A second start is pulsed in the middle of one run, at a point where the block is certainly busy, to exercise the ignore rule.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_DRV, S_TAPEN, S_TAPSEL, S_PDOFF, S_PDWAIT, S_PDON,
        S_CALRD, S_CALGAP, S_FREQ, S_DLLEN, S_DLLRD, S_DLLGAP, S_FIN
    } seq_state_e;

    localparam logic SEL_A = 1'b0;
    localparam logic SEL_B = 1'b1;

    // register B fields
    localparam int PWR_BIT  = 0;
    localparam int DLL_BIT  = 1;
    localparam int DRV_LSB  = 4;
    localparam int DRV_W    = 3;
    // register A fields
    localparam int TAPS_LSB = 7;
    localparam int TAPS_W   = 4;
    localparam int TAPE_BIT = 11;
    localparam int FSEL_LSB = 12;
    localparam int FSEL_W   = 2;
    localparam int TAP_SEL_VAL = 4;
    // status bits
    localparam int ST_CAL_BIT = 6;
    localparam int ST_DLL_BIT = 5;

    localparam logic [15:0] M_DRV  = 16'(((1 << DRV_W) - 1) << DRV_LSB);
    localparam logic [15:0] M_TAPS = 16'(((1 << TAPS_W) - 1) << TAPS_LSB);
    localparam logic [15:0] M_TAPE = 16'(1 << TAPE_BIT);
    localparam logic [15:0] M_FSEL = 16'(((1 << FSEL_W) - 1) << FSEL_LSB);
    localparam logic [15:0] M_PWR  = 16'(1 << PWR_BIT);
    localparam logic [15:0] M_DLL  = 16'(1 << DLL_BIT);

endpackage

// File: rtl/pbs_imp_code.sv
module pbs_imp_code #(
    parameter int IW = 8
) (
    input  logic [IW-1:0] ohm_i,
    output logic [2:0]    code_o
);
    always_comb begin
        case (ohm_i)
            IW'(33):  code_o = 3'd1;
            IW'(66):  code_o = 3'd2;
            IW'(100): code_o = 3'd3;
            IW'(40):  code_o = 3'd4;
            default:  code_o = 3'd0;   // 50 ohm and every unlisted request
        endcase
    end

    always_comb begin
        a_r1_code_range: assert (code_o <= 3'd4) else $error("R1 drive code out of range");
    end
endmodule

// File: rtl/pbs_freq_bin.sv
module pbs_freq_bin #(
    parameter int          FW    = 32,
    parameter logic [31:0] T_LO  = 32'd75_000_000,
    parameter logic [31:0] T_MID = 32'd125_000_000,
    parameter logic [31:0] T_HI  = 32'd175_000_000
) (
    input  logic [FW-1:0] hz_i,
    output logic [1:0]    band_o
);
    always_comb begin
        if (hz_i == '0)             band_o = 2'd0;
        else if (hz_i < FW'(T_LO))  band_o = 2'd1;
        else if (hz_i < FW'(T_MID)) band_o = 2'd2;
        else if (hz_i < FW'(T_HI))  band_o = 2'd3;
        else                        band_o = 2'd0;
    end

    always_comb begin
        if (hz_i == '0)
            a_r2_zero_band: assert (band_o == 2'd0) else $error("R2 zero frequency band");
    end
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import pbs_pkg::*;
#(
    parameter int CYC_PER_US = 100,
    parameter int PD_WAIT_US = 3,
    parameter int CAL_GAP_US = 10,
    parameter int DLL_GAP_US = 10000,
    parameter int POLL_TRIES = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [7:0]  imp_ohm_i,
    input  logic [31:0] clk_hz_i,
    input  logic [7:0]  stat_i,
    output logic        wr_en_o,
    output logic        wr_sel_o,
    output logic [15:0] wr_mask_o,
    output logic [15:0] wr_val_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_cal_o,
    output logic        err_dll_o
);
    localparam int PD_CYC  = PD_WAIT_US * CYC_PER_US;
    localparam int CAL_CYC = CAL_GAP_US * CYC_PER_US;
    localparam int DLL_CYC = DLL_GAP_US * CYC_PER_US;
    localparam int MAX_CYC = (DLL_CYC > CAL_CYC) ? ((DLL_CYC > PD_CYC) ? DLL_CYC : PD_CYC)
                                                 : ((CAL_CYC > PD_CYC) ? CAL_CYC : PD_CYC);
    localparam int CW = $clog2(MAX_CYC + 1);
    localparam int TW = $clog2(POLL_TRIES + 1);

    typedef struct packed {
        seq_state_e   st;
        logic [CW-1:0] cnt;
        logic [TW-1:0] tries;
        logic [2:0]   drv;
        logic [1:0]   fs;
        logic         fnz;
        logic         err_cal;
        logic         err_dll;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic [2:0] drv_code;
    logic [1:0] fs_code;

    pbs_imp_code #(.IW(8)) u_imp (.ohm_i(imp_ohm_i), .code_o(drv_code));
    pbs_freq_bin #(.FW(32)) u_fbin (.hz_i(clk_hz_i), .band_o(fs_code));

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.st      = S_DRV;
                    r_d.drv     = drv_code;
                    r_d.fs      = fs_code;
                    r_d.fnz     = (clk_hz_i != '0);
                    r_d.err_cal = 1'b0;
                    r_d.err_dll = 1'b0;
                end
            end
            S_DRV:    r_d.st = S_TAPEN;
            S_TAPEN:  r_d.st = S_TAPSEL;
            S_TAPSEL: r_d.st = S_PDOFF;
            S_PDOFF: begin
                r_d.st  = S_PDWAIT;
                r_d.cnt = CW'(PD_CYC - 1);
            end
            S_PDWAIT: begin
                if (r_q.cnt == '0) r_d.st = S_PDON;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            S_PDON: begin
                r_d.st    = S_CALRD;
                r_d.tries = '0;
            end
            S_CALRD: begin
                if (stat_i[ST_CAL_BIT]) begin
                    r_d.st = S_FREQ;
                end else begin
                    r_d.st    = S_CALGAP;
                    r_d.cnt   = CW'(CAL_CYC - 1);
                    r_d.tries = r_q.tries + 1'b1;
                end
            end
            S_CALGAP: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.tries == TW'(POLL_TRIES)) begin
                    r_d.err_cal = 1'b1;
                    r_d.st      = S_FREQ;
                end else begin
                    r_d.st = S_CALRD;
                end
            end
            S_FREQ: r_d.st = S_DLLEN;
            S_DLLEN: begin
                r_d.tries = '0;
                r_d.st    = r_q.fnz ? S_DLLRD : S_FIN;
            end
            S_DLLRD: begin
                if (stat_i[ST_DLL_BIT]) begin
                    r_d.st = S_FIN;
                end else begin
                    r_d.st    = S_DLLGAP;
                    r_d.cnt   = CW'(DLL_CYC - 1);
                    r_d.tries = r_q.tries + 1'b1;
                end
            end
            S_DLLGAP: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.tries == TW'(POLL_TRIES)) begin
                    r_d.err_dll = 1'b1;
                    r_d.st      = S_FIN;
                end else begin
                    r_d.st = S_DLLRD;
                end
            end
            S_FIN:   r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        wr_en_o   = 1'b1;
        wr_sel_o  = SEL_B;
        wr_mask_o = '0;
        wr_val_o  = '0;
        case (r_q.st)
            S_DRV: begin
                wr_mask_o = M_DRV;
                wr_val_o  = 16'(r_q.drv) << DRV_LSB;
            end
            S_TAPEN: begin
                wr_sel_o  = SEL_A;
                wr_mask_o = M_TAPE;
                wr_val_o  = M_TAPE;
            end
            S_TAPSEL: begin
                wr_sel_o  = SEL_A;
                wr_mask_o = M_TAPS;
                wr_val_o  = 16'(TAP_SEL_VAL) << TAPS_LSB;
            end
            S_PDOFF: wr_mask_o = M_PWR | M_DLL;
            S_PDON: begin
                wr_mask_o = M_PWR;
                wr_val_o  = M_PWR;
            end
            S_FREQ: begin
                wr_sel_o  = SEL_A;
                wr_mask_o = M_FSEL;
                wr_val_o  = 16'(r_q.fs) << FSEL_LSB;
            end
            S_DLLEN: begin
                wr_mask_o = M_DLL;
                wr_val_o  = M_DLL;
            end
            default: wr_en_o = 1'b0;
        endcase
    end

    assign busy_o    = (r_q.st != S_IDLE);
    assign done_o    = (r_q.st == S_FIN);
    assign err_cal_o = r_q.err_cal;
    assign err_dll_o = r_q.err_dll;

    a_r3_val_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ((wr_val_o & ~wr_mask_o) == 16'h0));
    a_r4_pwr_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_PDON) |-> $past(r_q.st == S_PDWAIT));
    a_r5_cal_err_from_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_cal_o) |-> $past(r_q.st == S_CALGAP));
    a_r6_dll_poll_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_DLLRD) |-> r_q.fnz);
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
    a_r8_busy_start_keeps_err: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (!$fell(err_cal_o) && !$fell(err_dll_o)));
endmodule

// File: tb/tb_phy_bringup_seq.sv
module tb_phy_bringup_seq;
    localparam int CPU = 2, PDU = 3, CALU = 3, DLLU = 5, TRIES = 5;
    localparam int NV = 9;
    localparam logic [7:0]  V_IMP [NV] = '{8'd50, 8'd33, 8'd66, 8'd100, 8'd40, 8'd47, 8'd0, 8'd255, 8'd33};
    localparam logic [31:0] V_HZ  [NV] = '{32'd0, 32'd50_000_000, 32'd74_999_999, 32'd75_000_000,
                                          32'd124_999_999, 32'd125_000_000, 32'd174_999_999,
                                          32'd175_000_000, 32'd200_000_000};
    localparam logic [2:0]  V_DRV [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0, 3'd0, 3'd0, 3'd1};
    localparam logic [1:0]  V_FS  [NV] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3, 2'd0, 2'd0};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] imp = 8'd50, stat = 8'd0;
    logic [31:0] hz = 32'd0;
    logic wr_en, wr_sel, busy, done, err_cal, err_dll;
    logic [15:0] wr_mask, wr_val;

    phy_bringup_seq #(.CYC_PER_US(CPU), .PD_WAIT_US(PDU), .CAL_GAP_US(CALU),
                      .DLL_GAP_US(DLLU), .POLL_TRIES(TRIES)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .imp_ohm_i(imp), .clk_hz_i(hz),
        .stat_i(stat), .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_mask_o(wr_mask),
        .wr_val_o(wr_val), .busy_o(busy), .done_o(done), .err_cal_o(err_cal), .err_dll_o(err_dll));

    always #4 clk = ~clk;

    int cyc = 0, nw = 0, done_cyc = 0, n_chk = 0, n_fail = 0;
    logic [32:0] wlog [256];
    int wcyc [256];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (wr_en) begin
            wlog[nw % 256] = {wr_sel, wr_mask, wr_val};
            wcyc[nw % 256] = cyc;
            nw = nw + 1;
        end
        if (done) done_cyc = cyc;
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [32:0] wr_at(input int base, input int k);
        return wlog[(base + k) % 256];
    endfunction

    function automatic int cyc_at(input int base, input int k);
        return wcyc[(base + k) % 256];
    endfunction

    task automatic run(input logic [7:0] i, input logic [31:0] h, input logic cal_ok,
                       input logic dll_ok, output int base);
        imp   = i;
        hz    = h;
        stat  = (8'(cal_ok) << 6) | (8'(dll_ok) << 5);
        base  = nw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int g = 0; g < 3000 && !done; g++) @(negedge clk);
        chk(done, "R7 done reached", done, 1);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int b;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!busy && !done && !wr_en && !err_cal && !err_dll, "R9 outputs in reset",
            {busy, done, wr_en, err_cal, err_dll}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && nw == 0 && !err_cal && !err_dll, "R9 idle after reset", nw, 0);

        // vector table: R1 drive code, R2 band code, R3 write count
        for (int v = 0; v < NV; v++) begin
            run(V_IMP[v], V_HZ[v], 1'b1, 1'b1, b);
            chk(nw - b == 7, "R3 write count", nw - b, 7);
            chk(wr_at(b, 0)[6:4] == V_DRV[v], "R1 drive code", wr_at(b, 0)[6:4], V_DRV[v]);
            chk(wr_at(b, 5)[13:12] == V_FS[v], "R2 band code", wr_at(b, 5)[13:12], V_FS[v]);
        end

        // R3 full order and encoding, R4 wait, R5 immediate calibration
        run(8'd66, 32'd100_000_000, 1'b1, 1'b1, b);
        chk(wr_at(b, 0) == {1'b1, 16'h0070, 16'h0020}, "R3 write1", wr_at(b, 0), {1'b1, 16'h0070, 16'h0020});
        chk(wr_at(b, 1) == {1'b0, 16'h0800, 16'h0800}, "R3 write2", wr_at(b, 1), {1'b0, 16'h0800, 16'h0800});
        chk(wr_at(b, 2) == {1'b0, 16'h0780, 16'h0200}, "R3 write3", wr_at(b, 2), {1'b0, 16'h0780, 16'h0200});
        chk(wr_at(b, 3) == {1'b1, 16'h0003, 16'h0000}, "R3 write4", wr_at(b, 3), {1'b1, 16'h0003, 16'h0000});
        chk(wr_at(b, 4) == {1'b1, 16'h0001, 16'h0001}, "R3 write5", wr_at(b, 4), {1'b1, 16'h0001, 16'h0001});
        chk(wr_at(b, 5) == {1'b0, 16'h3000, 16'h2000}, "R3 write6", wr_at(b, 5), {1'b0, 16'h3000, 16'h2000});
        chk(wr_at(b, 6) == {1'b1, 16'h0002, 16'h0002}, "R3 write7", wr_at(b, 6), {1'b1, 16'h0002, 16'h0002});
        chk(cyc_at(b, 4) - cyc_at(b, 3) == PDU * CPU + 1, "R4 power-down hold",
            cyc_at(b, 4) - cyc_at(b, 3), PDU * CPU + 1);
        chk(cyc_at(b, 5) - cyc_at(b, 4) == 2, "R5 cal first sample", cyc_at(b, 5) - cyc_at(b, 4), 2);
        chk(done_cyc - cyc_at(b, 6) == 2, "R6 dll first sample", done_cyc - cyc_at(b, 6), 2);
        chk(!err_cal && !err_dll, "R5 no error", {err_cal, err_dll}, 0);

        // R5 calibration timeout, sequence continues
        run(8'd50, 32'd50_000_000, 1'b0, 1'b1, b);
        chk(err_cal && !err_dll, "R5 cal timeout flag", {err_cal, err_dll}, 2);
        chk(cyc_at(b, 5) - cyc_at(b, 4) == TRIES * (CALU * CPU + 1) + 1, "R5 cal timeout length",
            cyc_at(b, 5) - cyc_at(b, 4), TRIES * (CALU * CPU + 1) + 1);
        chk(nw - b == 7, "R5 continues after timeout", nw - b, 7);

        // R7 error cleared by the next accepted start, busy after start
        imp = 8'd50; hz = 32'd0; stat = 8'h60;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R7 busy after start", busy, 1);
        chk(!err_cal, "R7 error cleared on start", err_cal, 0);
        for (int g = 0; g < 3000 && !done; g++) @(negedge clk);
        @(negedge clk);
        chk(!busy, "R7 idle after done", busy, 0);

        // R6 DLL timeout
        run(8'd40, 32'd150_000_000, 1'b1, 1'b0, b);
        chk(err_dll && !err_cal, "R6 dll timeout flag", {err_cal, err_dll}, 1);
        chk(done_cyc - cyc_at(b, 6) == TRIES * (DLLU * CPU + 1) + 1, "R6 dll timeout length",
            done_cyc - cyc_at(b, 6), TRIES * (DLLU * CPU + 1) + 1);

        // R6 zero frequency: no DLL poll
        run(8'd40, 32'd0, 1'b1, 1'b0, b);
        chk(!err_dll, "R6 zero freq no error", err_dll, 0);
        chk(done_cyc - cyc_at(b, 6) == 1, "R6 zero freq skips poll", done_cyc - cyc_at(b, 6), 1);

        // R8 start while busy is ignored (cal timeout sets err_cal first)
        imp = 8'd33; hz = 32'd0; stat = 8'h00;
        b = nw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int g = 0; g < 3000 && !done; g++) begin
            if (g == 45) begin
                imp = 8'd100; hz = 32'd100_000_000; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        chk(nw - b == 7, "R8 seven writes only", nw - b, 7);
        chk(wr_at(b, 0)[6:4] == 3'd1, "R8 drive code kept", wr_at(b, 0)[6:4], 1);
        chk(wr_at(b, 5)[13:12] == 2'd0, "R8 band code kept", wr_at(b, 5)[13:12], 0);
        chk(err_cal, "R8 error not cleared", err_cal, 1);
        repeat (4) @(negedge clk);
        chk(!busy && nw - b == 7, "R8 no second run", nw - b, 7);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule